// File: doc/BRIEF.md
# Two-Way Cache Maintenance Engine

This block owns the tag and state bits of a two-way set-associative cache with 16-byte lines and 4 KiB per way. That gives 256 sets and 8 KiB of capacity. It carries out maintenance work on those bits and does not serve normal loads and stores. A caller presents one command for one cycle while the engine is idle. The command either names a physical address (a per-line command) or covers the whole array (a sweep). The engine raises `busy` until the work is finished and then pulses `done` for one cycle.

Three maintenance flavours are supported, and each has its own rule for the valid and modified bits:

- **Invalidate** drops an entry outright.
- **Push** writes a dirty entry back and keeps it resident.
- **Clear** writes a dirty entry back and then drops it.

An entry that must be written back is offered on a simple memory-side port. The engine holds the request, with the line address, until the memory acknowledges it.

A per-line command looks the tag up in both ways of the indexed set. Line operation 0 is a search: it reports hit, way and dirty state. It can also install a tag into a chosen way, which is how tag fills reach the array. A sweep run with operation 0 is the enable/disable command. It invalidates everything and then sets the cache-enable and write-buffer-enable outputs together.

Top module: `cme_engine`

## Requirements
- R1: After reset every entry is invalid and clean; `busy`, `done`, `wb_req`, `cache_en` and `wbuf_en` are low.
- R2: Address bits [3:0] are ignored, bits [11:4] pick the set and bits [31:12] are the tag; a writeback address is tag, set and four zero bits.
- R3: A per-line command compares the tag against both ways of its set and reports `rsp_hit`, `rsp_way` (0 on a miss) and `rsp_dirty`. These reflect the state before the command. When no way matches, nothing changes. Operation 0 with `cmd_wr`=1 installs the tag into way `cmd_way` as valid, with the modified bit taken from `cmd_dirty`.
- R4: Invalidate clears valid and modified with no writeback.
- R5: Push writes back only a valid and modified entry and then clears only its modified bit. Any other entry is left as it was.
- R6: Clear writes back a valid and modified entry and then clears both bits. Otherwise it clears only the valid bit.
- R7: A sweep visits set 0 to 255 in rising order, way 0 before way 1. It takes one cycle per entry plus the cycles spent waiting for writebacks.
- R8: `wb_req` stays high with a steady `wb_addr` until a cycle with `wb_ack` high; the engine stalls meanwhile.
- R9: `busy` is high from the cycle after acceptance until completion. `done` is a one-cycle pulse in the first cycle with `busy` low. A per-line command without a writeback is busy for one cycle.
- R10: A command presented while `busy` is high is ignored.
- R11: A sweep with operation 0 invalidates the whole array with no writebacks. On completion, `cache_en` and `wbuf_en` both take the value of `cmd_en`; before then they keep their old value.
- R12: `cmd_op` encoding: 0 search/install, 1 invalidate, 2 push, 3 clear; `cmd_all`=1 selects a sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_all | input | 1 | 1 = whole-array sweep, 0 = per-line command |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | 32 | Physical address for per-line commands |
| cmd_wr | input | 1 | With operation 0: install instead of search |
| cmd_way | input | 1 | Way that an install writes |
| cmd_dirty | input | 1 | Modified bit written by an install |
| cmd_en | input | 1 | Enable value applied by an operation-0 sweep |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Per-line lookup hit |
| rsp_way | output | 1 | Way that hit |
| rsp_dirty | output | 1 | Modified bit of the hit entry |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | 32 | Line address being written back |
| wb_ack | input | 1 | Writeback acknowledge |
| cache_en | output | 1 | Cache enable |
| wbuf_en | output | 1 | Write-buffer enable |

## Verification
The bench targets the places where the three flavours differ:

- **Repeated push.** A second push of a line that was already pushed must not write back again. A design that forgot to clear the modified bit would write back twice. One that cleared valid would make the line miss afterwards.
- **Clear of a clean resident line.** This must drop the line without any write. A design that returned early would leave the line hitting.
- **Misses.** Commands to a same-set, different-tag address must leave both resident ways alone.
- **Sweep ordering and length.** The first and last writeback addresses and the busy-cycle counts, with and without acknowledge delay, expose a walk that skips entries, visits them in the wrong order, or does not stall.
- **Flags and injected commands.** The enable flags are sampled mid-sweep to catch early update. A command injected during a sweep must leave no installed line.

// File: rtl/cme_pkg.sv
`timescale 1ns/1ps
package cme_pkg;

   // Operation codes on cmd_op
   typedef enum logic [1:0] {
      OP_RW   = 2'd0,
      OP_INV  = 2'd1,
      OP_PUSH = 2'd2,
      OP_CLR  = 2'd3
   } cme_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LINE  = 2'd1,
      ST_SWEEP = 2'd2,
      ST_WB    = 2'd3
   } cme_state_e;

endpackage

// File: rtl/cme_tag_store.sv
`timescale 1ns/1ps
// Tag/valid/modified storage: one combinational read port (all ways of a set),
// one synchronous write port (one entry). Valid and modified bits reset to 0.
module cme_tag_store #(
   parameter int SETS     = 256,
   parameter int NUM_WAYS = 2,
   parameter int TAG_W    = 20,
   localparam int SET_W   = $clog2(SETS),
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [SET_W-1:0]                 rd_set,
   output logic [NUM_WAYS-1:0][TAG_W-1:0]   rd_tag,
   output logic [NUM_WAYS-1:0]              rd_vld,
   output logic [NUM_WAYS-1:0]              rd_mod,
   input  logic                             wr_en,
   input  logic [SET_W-1:0]                 wr_set,
   input  logic [WAY_W-1:0]                 wr_way,
   input  logic [TAG_W-1:0]                 wr_tag,
   input  logic                             wr_vld,
   input  logic                             wr_mod
);

   logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q [SETS];
   logic [NUM_WAYS-1:0]            vld_q [SETS];
   logic [NUM_WAYS-1:0]            mod_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            mod_q[s] <= '0;
         end
      end else if (wr_en) begin
         vld_q[wr_set][wr_way] <= wr_vld;
         mod_q[wr_set][wr_way] <= wr_mod;
      end
   end

   // Tags need no reset: a tag is only meaningful with its valid bit set.
   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_set][wr_way] <= wr_tag;
      end
   end

   assign rd_tag = tag_q[rd_set];
   assign rd_vld = vld_q[rd_set];
   assign rd_mod = mod_q[rd_set];

endmodule

// File: rtl/cme_way_match.sv
`timescale 1ns/1ps
// Compares a key tag against every way of a set; the lowest matching way wins.
module cme_way_match #(
   parameter int NUM_WAYS = 2,
   parameter int TAG_W    = 20,
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags,
   input  logic [NUM_WAYS-1:0]            vld,
   input  logic [TAG_W-1:0]               key,
   output logic                           hit,
   output logic [WAY_W-1:0]               way
);

   logic [NUM_WAYS-1:0] match;

   for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
      assign match[g] = vld[g] && (tags[g] == key);
   end

   assign hit = |match;

   if (NUM_WAYS == 2) begin : g_pair
      // Two ways: way 1 is selected only when way 0 does not match.
      assign way = WAY_W'(~match[0] & match[1]);
   end else begin : g_wide
      always_comb begin
         way = '0;
         for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (match[i]) way = WAY_W'(i);
         end
      end
   end

endmodule

// File: rtl/cme_walk_ctr.sv
`timescale 1ns/1ps
// Sweep pointer. The way index sits in the low bits, so all ways of a set
// are visited before the next set.
module cme_walk_ctr #(
   parameter int SETS     = 256,
   parameter int NUM_WAYS = 2,
   localparam int SET_W   = $clog2(SETS),
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [SET_W-1:0] set_idx,
   output logic [WAY_W-1:0] way_idx,
   output logic             last
);

   localparam int PTR_W   = SET_W + WAY_W;
   localparam int ENTRIES = SETS * NUM_WAYS;

   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr_q <= '0;
      else if (clr)  ptr_q <= '0;
      else if (step) ptr_q <= ptr_q + PTR_W'(1);
   end

   assign set_idx = ptr_q[PTR_W-1:WAY_W];
   assign way_idx = ptr_q[WAY_W-1:0];
   assign last    = (ptr_q == PTR_W'(ENTRIES - 1));

endmodule

// File: rtl/cme_engine.sv
`timescale 1ns/1ps
module cme_engine #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int WAY_BYTES  = 4096,
   parameter int NUM_WAYS   = 2,
   localparam int WAY_W     = $clog2(NUM_WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_all,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              cmd_wr,
   input  logic [WAY_W-1:0]  cmd_way,
   input  logic              cmd_dirty,
   input  logic              cmd_en,
   output logic              busy,
   output logic              done,
   output logic              rsp_hit,
   output logic [WAY_W-1:0]  rsp_way,
   output logic              rsp_dirty,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_addr,
   input  logic              wb_ack,
   output logic              cache_en,
   output logic              wbuf_en
);
   import cme_pkg::*;

   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int SETS   = WAY_BYTES / LINE_BYTES;
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
   localparam int LINE_W = ADDR_W - OFF_W;

   // Elaboration-time parameter checks
   if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if ((1 << SET_W) != SETS) begin : g_bad_sets
      $error("WAY_BYTES / LINE_BYTES must be a power of two");
   end
   if (NUM_WAYS < 2 || (1 << WAY_W) != NUM_WAYS) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the cache geometry");
   end

   // Latched command
   cme_state_e        state_q, state_d;
   cme_op_e           op_q;
   logic              all_q, wr_q, dirty_q, en_q;
   logic [WAY_W-1:0]  way_q;
   logic [LINE_W-1:0] line_q;

   // Registered outputs
   logic              done_q, rsp_hit_q, rsp_dirty_q, cache_en_q, wbuf_en_q;
   logic [WAY_W-1:0]  rsp_way_q;
   logic [ADDR_W-1:0] wb_addr_q;

   // Storage ports
   logic [SET_W-1:0]                 rd_set;
   logic [NUM_WAYS-1:0][TAG_W-1:0]   rd_tag;
   logic [NUM_WAYS-1:0]              rd_vld, rd_mod;
   logic                             wr_en, wr_vld, wr_mod;
   logic [SET_W-1:0]                 wr_set;
   logic [WAY_W-1:0]                 wr_way;
   logic [TAG_W-1:0]                 wr_tag;

   // Lookup and walk
   logic              hit;
   logic [WAY_W-1:0]  hit_way;
   logic [SET_W-1:0]  walk_set;
   logic [WAY_W-1:0]  walk_way;
   logic              walk_last, walk_clr, walk_step;

   // Derived control
   logic [SET_W-1:0]  line_set, cur_set;
   logic [TAG_W-1:0]  line_tag, cur_tag;
   logic [WAY_W-1:0]  cur_way;
   logic              cur_v, cur_m, present, dirty_hit, visit;
   logic              accept, go_wb, entry_done, finish;
   cme_op_e           eff_op;

   // Offset bits of the command address play no part in any decision.
   logic              unused_offset;
   assign unused_offset = ^cmd_addr[OFF_W-1:0];

   assign line_set = line_q[SET_W-1:0];
   assign line_tag = line_q[LINE_W-1:SET_W];

   cme_tag_store #(
      .SETS(SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_set(rd_set), .rd_tag(rd_tag), .rd_vld(rd_vld), .rd_mod(rd_mod),
      .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way),
      .wr_tag(wr_tag), .wr_vld(wr_vld), .wr_mod(wr_mod)
   );

   cme_way_match #(
      .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)
   ) u_match (
      .tags(rd_tag), .vld(rd_vld), .key(line_tag),
      .hit(hit), .way(hit_way)
   );

   cme_walk_ctr #(
      .SETS(SETS), .NUM_WAYS(NUM_WAYS)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .clr(walk_clr), .step(walk_step),
      .set_idx(walk_set), .way_idx(walk_way), .last(walk_last)
   );

   // Entry selection: the sweep pointer or the lookup result
   always_comb begin
      cur_set   = all_q ? walk_set : line_set;
      rd_set    = cur_set;
      cur_way   = all_q ? walk_way : hit_way;
      cur_tag   = rd_tag[cur_way];
      cur_v     = rd_vld[cur_way];
      cur_m     = rd_mod[cur_way];
      // A whole-array operation 0 is the enable/disable command: invalidate everything.
      eff_op    = (all_q && op_q == OP_RW) ? OP_INV : op_q;
      present   = all_q | hit;
      dirty_hit = present & cur_v & cur_m;
      visit     = (state_q == ST_LINE) || (state_q == ST_SWEEP);
      accept    = (state_q == ST_IDLE) && cmd_valid;
      go_wb     = visit && dirty_hit && (eff_op == OP_PUSH || eff_op == OP_CLR);
      entry_done = (visit && !go_wb) || (state_q == ST_WB && wb_ack);
      finish    = entry_done && (!all_q || walk_last);
      walk_clr  = accept;
      walk_step = entry_done && all_q && !walk_last;
   end

   // Next state
   always_comb begin
      state_d = state_q;
      if (accept)          state_d = cmd_all ? ST_SWEEP : ST_LINE;
      else if (go_wb)      state_d = ST_WB;
      else if (finish)     state_d = ST_IDLE;
      else if (entry_done) state_d = ST_SWEEP;
   end

   // State-bit update rules
   always_comb begin
      wr_en  = 1'b0;
      wr_set = cur_set;
      wr_way = cur_way;
      wr_tag = cur_tag;
      wr_vld = cur_v;
      wr_mod = cur_m;
      if (visit) begin
         unique case (eff_op)
            OP_RW: begin
               if (wr_q) begin
                  wr_en  = 1'b1;
                  wr_way = way_q;
                  wr_tag = line_tag;
                  wr_vld = 1'b1;
                  wr_mod = dirty_q;
               end
            end
            OP_INV: begin
               if (present) begin
                  wr_en  = 1'b1;
                  wr_vld = 1'b0;
                  wr_mod = 1'b0;
               end
            end
            OP_PUSH: begin
               // Clean or absent entries stay as they are; dirty ones go to ST_WB.
            end
            OP_CLR: begin
               if (present && !dirty_hit) begin
                  wr_en  = 1'b1;
                  wr_vld = 1'b0;
               end
            end
            default: ;
         endcase
      end else if (state_q == ST_WB && wb_ack) begin
         wr_en  = 1'b1;
         wr_mod = 1'b0;
         if (eff_op == OP_CLR) wr_vld = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         op_q        <= OP_RW;
         all_q       <= 1'b0;
         wr_q        <= 1'b0;
         dirty_q     <= 1'b0;
         en_q        <= 1'b0;
         way_q       <= '0;
         line_q      <= '0;
         done_q      <= 1'b0;
         rsp_hit_q   <= 1'b0;
         rsp_way_q   <= '0;
         rsp_dirty_q <= 1'b0;
         wb_addr_q   <= '0;
         cache_en_q  <= 1'b0;
         wbuf_en_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
         if (accept) begin
            all_q   <= cmd_all;
            op_q    <= cme_op_e'(cmd_op);
            wr_q    <= cmd_wr;
            dirty_q <= cmd_dirty;
            en_q    <= cmd_en;
            way_q   <= cmd_way;
            line_q  <= cmd_addr[ADDR_W-1:OFF_W];
         end
         if (state_q == ST_LINE) begin
            rsp_hit_q   <= hit;
            rsp_way_q   <= hit ? hit_way : '0;
            rsp_dirty_q <= hit & cur_m;
         end
         if (go_wb) begin
            wb_addr_q <= {cur_tag, cur_set, {OFF_W{1'b0}}};
         end
         if (finish && all_q && op_q == OP_RW) begin
            cache_en_q <= en_q;
            wbuf_en_q  <= en_q;
         end
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign rsp_hit   = rsp_hit_q;
   assign rsp_way   = rsp_way_q;
   assign rsp_dirty = rsp_dirty_q;
   assign wb_req    = (state_q == ST_WB);
   assign wb_addr   = wb_addr_q;
   assign cache_en  = cache_en_q;
   assign wbuf_en   = wbuf_en_q;

endmodule

// File: rtl/cme_engine_chk.sv
`timescale 1ns/1ps
module cme_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              wb_req,
   input logic              wb_ack,
   input logic [ADDR_W-1:0] wb_addr,
   input logic              cache_en,
   input logic              wbuf_en
);

   // R8
   wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

   // R8
   wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && wb_ack) |=> !wb_req);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R9
   fall_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R11
   en_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cache_en) |-> done);

   // R11
   en_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cache_en == wbuf_en);

endmodule

bind cme_engine cme_engine_chk #(.ADDR_W(ADDR_W)) u_cme_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .wb_req(wb_req), .wb_ack(wb_ack), .wb_addr(wb_addr),
   .cache_en(cache_en), .wbuf_en(wbuf_en)
);

// File: tb/cme_engine_bench.sv
`timescale 1ns/1ps
module cme_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_all = 1'b0, cmd_wr = 1'b0;
   logic        cmd_way = 1'b0, cmd_dirty = 1'b0, cmd_en = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [31:0] cmd_addr = '0;
   logic        wb_ack = 1'b0;
   logic        busy, done, rsp_hit, rsp_way, rsp_dirty, wb_req, cache_en, wbuf_en;
   logic [31:0] wb_addr;

   int total = 0, bad = 0;
   int nwb, busy_cyc, ack_delay = 0, inject_at = -1;
   logic [31:0] first_wb, last_wb;
   logic mid_en;

   always #2.5 clk = ~clk;

   cme_engine u_cme_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_all(cmd_all),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wr(cmd_wr), .cmd_way(cmd_way),
      .cmd_dirty(cmd_dirty), .cmd_en(cmd_en), .busy(busy), .done(done),
      .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_dirty(rsp_dirty),
      .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
      .cache_en(cache_en), .wbuf_en(wbuf_en)
   );

   typedef struct packed {
      logic [1:0]  op;
      logic        wr;
      logic        way;
      logic        dirty;
      logic [31:0] addr;
      logic        rd_chk;
      logic        e_hit;
      logic        e_way;
      logic        e_dirty;
      logic [1:0]  e_nwb;
      logic [31:0] e_wb;
   } vec_t;

   localparam int NV = 23;
   // X=0x1230 (set 0x23 tag 1), Y=0x2230 (set 0x23 tag 2), Z=0x3230 same set miss
   localparam vec_t VECS [NV] = '{
      '{2'd0, 1'b1, 1'b0, 1'b0, 32'h0000_1230, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b1, 1'b1, 1'b1, 32'h0000_2238, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_123C, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_2230, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 32'h0},
      '{2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_2234, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_2230},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_2230, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0},
      '{2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_2230, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_1230, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_1230, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0000_3230, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_3230, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_1230, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_2230, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_5400, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd3, 1'b0, 1'b0, 1'b0, 32'h0000_540F, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_5400},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_5400, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd3, 1'b0, 1'b0, 1'b0, 32'h0000_1230, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_1230, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b1, 1'b1, 1'b1, 32'h0000_6400, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_6400, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 32'h0},
      '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0000_6400, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_6400, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
      '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_2230, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Issues one command and services writebacks until done.
   task automatic issue(input logic all, input logic [1:0] op, input logic [31:0] addr,
                        input logic wr, input logic way, input logic dirty, input logic en);
      int  wait_cnt;
      bit  got_done;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_all = all; cmd_op = op; cmd_addr = addr;
      cmd_wr = wr; cmd_way = way; cmd_dirty = dirty; cmd_en = en;
      nwb = 0; busy_cyc = 0; wait_cnt = 0; got_done = 1'b0;
      first_wb = '0; last_wb = '0; mid_en = 1'bx;
      for (int it = 0; it < 4000; it++) begin
         @(negedge clk);
         cmd_valid = 1'b0;
         wb_ack = 1'b0;
         if (it == inject_at) begin
            cmd_valid = 1'b1; cmd_all = 1'b0; cmd_op = 2'd0; cmd_wr = 1'b1;
            cmd_way = 1'b0; cmd_dirty = 1'b1; cmd_addr = 32'h0006_6660;
         end
         if (it == 100) mid_en = cache_en;
         if (done) begin
            got_done = 1'b1;
            break;
         end
         if (busy) busy_cyc++;
         if (wb_req) begin
            if (wait_cnt >= ack_delay) begin
               wb_ack = 1'b1;
               if (nwb == 0) first_wb = wb_addr;
               last_wb = wb_addr;
               nwb++;
               wait_cnt = 0;
            end else begin
               wait_cnt++;
            end
         end
      end
      cmd_valid = 1'b0;
      if (!got_done) begin
         total++; bad++;
         $display("FAIL R9: command never completed, actual=busy expected=done");
      end
   endtask

   task automatic read_line(input logic [31:0] addr);
      issue(1'b0, 2'd0, addr, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic fill(input logic [31:0] addr, input logic way, input logic dirty);
      issue(1'b0, 2'd0, addr, 1'b1, way, dirty, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1 busy", 32'(busy), 0);
      check("R1 done", 32'(done), 0);
      check("R1 wb_req", 32'(wb_req), 0);
      check("R1 cache_en", 32'(cache_en), 0);
      check("R1 wbuf_en", 32'(wbuf_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      read_line(32'h0000_0000);
      check("R1 array empty after reset", 32'(rsp_hit), 0);

      // Table-driven per-line tests (R2 R3 R4 R5 R6 R12)
      ack_delay = 1;
      for (int i = 0; i < NV; i++) begin
         issue(1'b0, VECS[i].op, VECS[i].addr, VECS[i].wr, VECS[i].way, VECS[i].dirty, 1'b0);
         check($sformatf("R12 row %0d writeback count (R4 R5 R6)", i), 32'(nwb), 32'(VECS[i].e_nwb));
         if (VECS[i].e_nwb != 0)
            check($sformatf("R2 row %0d writeback address", i), last_wb, VECS[i].e_wb);
         if (VECS[i].rd_chk) begin
            check($sformatf("R3 row %0d hit", i), 32'(rsp_hit), 32'(VECS[i].e_hit));
            check($sformatf("R3 row %0d way", i), 32'(rsp_way), 32'(VECS[i].e_way));
            check($sformatf("R3 row %0d dirty", i), 32'(rsp_dirty), 32'(VECS[i].e_dirty));
         end
      end

      // R9 a plain lookup is busy for one cycle
      ack_delay = 0;
      read_line(32'h0000_2230);
      check("R9 line busy cycles", 32'(busy_cyc), 1);

      // R7 R8 push sweep with acknowledge delay: order and stall length
      fill(32'hAAAA_A000, 1'b0, 1'b1);
      fill(32'h0001_0800, 1'b1, 1'b1);
      fill(32'h0000_7FF0, 1'b1, 1'b1);
      fill(32'h0000_5100, 1'b0, 1'b0);
      ack_delay = 3;
      issue(1'b1, 2'd2, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      // 0x2230 was already clean, so only the three dirty fills write back
      check("R5 push sweep writebacks", 32'(nwb), 3);
      check("R7 first writeback set 0", first_wb, 32'hAAAA_A000);
      check("R7 last writeback set 255", last_wb, 32'h0000_7FF0);
      check("R8 busy cycles with stalls", 32'(busy_cyc), 512 + 3 * 4);
      ack_delay = 0;
      read_line(32'hAAAA_A000);
      check("R5 push sweep keeps valid", 32'(rsp_hit), 1);
      check("R5 push sweep clears modified", 32'(rsp_dirty), 0);

      // R6 clear sweep
      fill(32'h0001_0800, 1'b1, 1'b1);
      fill(32'h0003_3330, 1'b0, 1'b1);
      issue(1'b1, 2'd3, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R6 clear sweep writebacks", 32'(nwb), 2);
      check("R7 clear sweep order first", first_wb, 32'h0003_3330);
      check("R7 clear sweep order last", last_wb, 32'h0001_0800);
      check("R7 clear sweep busy cycles", 32'(busy_cyc), 514);
      read_line(32'hAAAA_A000);
      check("R6 clean line dropped by clear sweep", 32'(rsp_hit), 0);
      read_line(32'h0001_0800);
      check("R6 dirty line dropped by clear sweep", 32'(rsp_hit), 0);

      // R4 R10 invalidate sweep with a command injected while busy
      fill(32'h0004_4440, 1'b1, 1'b1);
      inject_at = 10;
      issue(1'b1, 2'd1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      inject_at = -1;
      check("R4 invalidate sweep writebacks", 32'(nwb), 0);
      check("R7 invalidate sweep busy cycles", 32'(busy_cyc), 512);
      read_line(32'h0004_4440);
      check("R4 dirty line dropped", 32'(rsp_hit), 0);
      read_line(32'h0006_6660);
      check("R10 command while busy ignored", 32'(rsp_hit), 0);

      // R11 enable then disable
      fill(32'h0005_5550, 1'b0, 1'b1);
      issue(1'b1, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
      check("R11 enable unchanged mid-sweep", 32'(mid_en), 0);
      check("R11 enable sweep writebacks", 32'(nwb), 0);
      check("R11 cache_en set", 32'(cache_en), 1);
      check("R11 wbuf_en set", 32'(wbuf_en), 1);
      read_line(32'h0005_5550);
      check("R11 enable invalidates", 32'(rsp_hit), 0);
      issue(1'b1, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R11 cache_en cleared", 32'(cache_en), 0);
      check("R11 wbuf_en cleared", 32'(wbuf_en), 0);

      @(negedge clk);
      check("R9 done lasts one cycle", 32'(done), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule